// File: doc/BRIEF.md
# AHB burst master sequencer

This block is the address-and-control engine of an AHB-Lite bus master. A local client hands it one transfer request at a time (start address, direction, beat size, burst kind and, for undefined-length bursts, a beat count). The sequencer then drives the transfer-type, address and control outputs beat by beat. It follows the bus rule that the address phase of the next beat overlaps the data phase of the current one, and it freezes whenever the slave inserts wait states.

Each following address is computed here, for incrementing and for wrapping bursts. When the local data source cannot supply or absorb the next beat, the sequencer inserts BUSY cycles in the middle of the burst. An incrementing burst is never allowed to run across a 1KB address boundary. The local side receives a pulse for each beat whose data phase has completed, together with the read data and a flag that marks the final beat of the request.

Top module: `ahb_burst_seq`

## Requirements
- R1: While reset is held, and after it is released with no request pending, `htrans` is IDLE (2'b00) and `beat_done` is low.
- R2: In any cycle where `hready` is low, the next cycle shows the same `htrans`, `haddr`, `hsize`, `hburst`, `hwrite` and `hwdata`.
- R3: Transfer types are encoded IDLE=00, BUSY=01, NONSEQ=10, SEQ=11. The first beat of every request is NONSEQ. Every later beat is SEQ unless R8 applies.
- R4: In an incrementing burst (HBURST codes 001, 011, 101, 111), each beat address is the previous beat address plus 2^`hsize` bytes.
- R5: In a wrapping burst (codes 010, 100, 110), beat i sits at base | ((start + i·2^hsize) mod W). Here W = beats·2^hsize and base is the start address rounded down to a multiple of W.
- R6: Beat counts follow the code. 000 single gives 1 beat. 010/011 give 4, 100/101 give 8 and 110/111 give 16. Code 001 gives `req_len` beats, with 0 treated as 1. After the counted beats, no further transfer of that request appears.
- R7: If `src_valid` is low when the next beat of a request would be issued, and that beat does not start a new 1KB block, the sequencer drives BUSY with the next beat's address. BUSY is only ever followed by BUSY or SEQ.
- R8: A beat of an incrementing burst whose address is a multiple of 1024 is driven as NONSEQ, so no SEQ beat of an incrementing burst has an address with its low 10 bits zero. If the source stalls at that point, IDLE is driven instead of BUSY.
- R9: A fixed-length incrementing request (011, 101, 111) whose span crosses a 1KB boundary is driven with `hburst` = 001 for all of its beats.
- R10: `hsize`, `hwrite` and `hburst` stay constant for every beat of a request.
- R11: `src_take` pulses when `hready` and `src_valid` are high and a beat is being issued. The `src_data` sampled with that pulse appears on `hwdata` throughout the data phase of that beat.
- R12: `beat_done` is high exactly in the cycles where a data phase completes (`hready` high). `beat_last` marks the final beat of a request, `beat_write` gives the direction, and `beat_rdata` carries `hrdata`.
- R13: `req_ready` is high exactly when `hready` and `src_valid` are high and every beat of the previous request has been issued. An accepted request puts its NONSEQ beat on the bus in the next cycle, back to back. Otherwise IDLE follows the last beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A transfer request is offered |
| req_ready | output | 1 | The request is taken at this edge |
| req_addr | input | AW | Start byte address, aligned to the beat size |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 3 | Beat size as log2 of bytes |
| req_burst | input | 3 | Burst kind code |
| req_len | input | LW | Beat count for undefined-length bursts |
| src_valid | input | 1 | Local side can supply or absorb the next beat |
| src_take | output | 1 | A beat is issued at this edge; `src_data` is captured |
| src_data | input | DW | Write data for the beat being issued |
| beat_done | output | 1 | A data phase completes in this cycle |
| beat_write | output | 1 | Direction of the completing beat |
| beat_last | output | 1 | The completing beat is the final beat of its request |
| beat_rdata | output | DW | Read data of the completing beat |
| htrans | output | 2 | Bus transfer type |
| haddr | output | AW | Bus address |
| hsize | output | 3 | Bus beat size |
| hburst | output | 3 | Bus burst kind |
| hwrite | output | 1 | Bus direction |
| hwdata | output | DW | Bus write data |
| hready | input | 1 | Slave ready; low stretches the current phase |
| hrdata | input | DW | Bus read data |

## Verification
Two things can fall in the same cycle: the source stall that would produce a BUSY, and the arrival of an incrementing burst at a 1KB boundary. That coincidence must produce IDLE and then a NONSEQ restart, never a BUSY. Slave wait states can also land on any of these cycles. The stimulus aims undefined-length and fixed incrementing bursts at addresses just below a 1KB boundary, while `src_valid` and `hready` drop at random. A bench model derives every expected beat address, its transfer type and the converted burst code from the request alone. Any BUSY, IDLE or SEQ seen where that model calls for something else is reported against its requirement.

// File: rtl/ahb_burst_seq_pkg.sv
// Shared types and helpers for the AHB burst master sequencer.
// Assumes the standard AHB transfer-type and burst-kind encodings.
package ahb_burst_seq_pkg;

    typedef enum logic [1:0] {
        TR_IDLE = 2'b00,
        TR_BUSY = 2'b01,
        TR_NSEQ = 2'b10,
        TR_SEQ  = 2'b11
    } trans_e;

    localparam logic [2:0] BK_SINGLE = 3'b000;
    localparam logic [2:0] BK_INCR   = 3'b001;

    // Wrapping kinds are the even non-zero codes.
    function automatic logic kind_wraps(input logic [2:0] kind);
        return (kind[0] == 1'b0) && (kind != BK_SINGLE);
    endfunction

    // Incrementing kinds are the odd codes.
    function automatic logic kind_incr(input logic [2:0] kind);
        return kind[0];
    endfunction

    // Beat count implied by a fixed-length code (1 for single and undefined).
    function automatic logic [4:0] kind_beats(input logic [2:0] kind);
        case (kind[2:1])
            2'b01:   return 5'd4;
            2'b10:   return 5'd8;
            2'b11:   return 5'd16;
            default: return 5'd1;
        endcase
    endfunction

endpackage

// File: rtl/ahb_burst_seq_req_decode.sv
// Request decoder: derives the total beat count of a request and the
// burst code actually driven on the bus. A fixed incrementing request
// whose span would cross a boundary block is demoted to undefined length
// so that the address stage can split it.
// Assumes req_addr is aligned to the beat size.
module ahb_burst_seq_req_decode
    import ahb_burst_seq_pkg::*;
#(
    parameter int AW      = 32,
    parameter int LW      = 8,
    parameter int CW      = 8,
    parameter int KB_BITS = 10
) (
    input  logic [AW-1:0] req_addr,
    input  logic [2:0]    req_size,
    input  logic [2:0]    req_burst,
    input  logic [LW-1:0] req_len,
    output logic [CW-1:0] total_beats,
    output logic [2:0]    bus_burst
);

    logic [CW-1:0] beats_w;
    logic [AW-1:0] span_m1;
    logic [AW-1:0] end_addr;
    logic          spans_edge;

    // Beat count and boundary test for the offered request.
    always_comb begin
        if (req_burst == BK_INCR) begin
            beats_w = (req_len == '0) ? CW'(1) : CW'(req_len);
        end else begin
            beats_w = CW'(kind_beats(req_burst));
        end
        span_m1    = (AW'(beats_w) - AW'(1)) << req_size;
        end_addr   = req_addr + span_m1;
        spans_edge = kind_incr(req_burst) && (req_burst != BK_INCR) &&
                     (req_addr[AW-1:KB_BITS] != end_addr[AW-1:KB_BITS]);
        bus_burst  = spans_edge ? BK_INCR : req_burst;
    end

    assign total_beats = beats_w;

endmodule

// File: rtl/ahb_burst_seq_addr_step.sv
// Next-address generator: advances an address by one beat of the given
// size, folding it back inside the aligned wrap block for wrapping kinds.
// Purely combinational.
module ahb_burst_seq_addr_step
    import ahb_burst_seq_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] cur_addr,
    input  logic [2:0]    size,
    input  logic [2:0]    kind,
    output logic [AW-1:0] nxt_addr
);

    logic [AW-1:0] stride;
    logic [AW-1:0] wrap_mask;
    logic [AW-1:0] plain_nxt;

    // Linear advance and wrap folding.
    always_comb begin
        stride    = AW'(1) << size;
        wrap_mask = (AW'(kind_beats(kind)) << size) - AW'(1);
        plain_nxt = cur_addr + stride;
        if (kind_wraps(kind)) begin
            nxt_addr = (cur_addr & ~wrap_mask) | (plain_nxt & wrap_mask);
        end else begin
            nxt_addr = plain_nxt;
        end
    end

endmodule

// File: rtl/ahb_burst_seq_addr_phase.sv
// Address-phase controller: owns the transfer type, address and control
// registers on the bus. It issues NONSEQ/SEQ beats, inserts BUSY when the
// local source stalls mid-burst, restarts incrementing bursts with NONSEQ
// at a boundary block, and holds everything while the slave is not ready.
// Assumes requests are aligned and their size fits the data bus.
module ahb_burst_seq_addr_phase
    import ahb_burst_seq_pkg::*;
#(
    parameter int AW      = 32,
    parameter int DW      = 32,
    parameter int LW      = 8,
    parameter int CW      = 8,
    parameter int KB_BITS = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hready,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic          req_write,
    input  logic [2:0]    req_size,
    input  logic [2:0]    req_burst,
    input  logic [LW-1:0] req_len,
    input  logic          src_valid,
    input  logic [DW-1:0] src_data,
    output logic          req_ready,
    output logic          src_take,
    output logic [1:0]    htrans,
    output logic [AW-1:0] haddr,
    output logic [2:0]    hsize,
    output logic [2:0]    hburst,
    output logic          hwrite,
    output logic [DW-1:0] a_wdata,
    output logic          a_last
);

    trans_e        trans_q;
    logic [AW-1:0] addr_q;
    logic [2:0]    size_q;
    logic [2:0]    kind_q;
    logic          write_q;
    logic [DW-1:0] wdata_q;
    logic          last_q;
    logic [CW-1:0] left_q;

    logic [CW-1:0] dec_beats;
    logic [2:0]    dec_burst;
    logic [AW-1:0] stepped;
    logic [AW-1:0] next_addr;
    logic          more;
    logic          parked;
    logic          at_edge;

    ahb_burst_seq_req_decode #(
        .AW(AW), .LW(LW), .CW(CW), .KB_BITS(KB_BITS)
    ) u_decode (
        .req_addr   (req_addr),
        .req_size   (req_size),
        .req_burst  (req_burst),
        .req_len    (req_len),
        .total_beats(dec_beats),
        .bus_burst  (dec_burst)
    );

    ahb_burst_seq_addr_step #(
        .AW(AW)
    ) u_step (
        .cur_addr(addr_q),
        .size    (size_q),
        .kind    (kind_q),
        .nxt_addr(stepped)
    );

    // Pending-beat address: a parked cycle already shows the next address.
    always_comb begin
        more      = (left_q != '0);
        parked    = (trans_q == TR_BUSY) || (trans_q == TR_IDLE);
        next_addr = parked ? addr_q : stepped;
        at_edge   = kind_incr(kind_q) && (next_addr[KB_BITS-1:0] == '0);
    end

    assign req_ready = hready && !more && src_valid;
    assign src_take  = hready && src_valid && (more || req_valid);

    // Address-phase state: advances only on an edge with hready high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trans_q <= TR_IDLE;
            addr_q  <= '0;
            size_q  <= '0;
            kind_q  <= '0;
            write_q <= 1'b0;
            wdata_q <= '0;
            last_q  <= 1'b0;
            left_q  <= '0;
        end else if (hready) begin
            if (more) begin
                addr_q <= next_addr;
                if (src_valid) begin
                    trans_q <= at_edge ? TR_NSEQ : TR_SEQ;
                    wdata_q <= src_data;
                    left_q  <= left_q - CW'(1);
                    last_q  <= (left_q == CW'(1));
                end else begin
                    trans_q <= at_edge ? TR_IDLE : TR_BUSY;
                    last_q  <= 1'b0;
                end
            end else if (req_valid && src_valid) begin
                trans_q <= TR_NSEQ;
                addr_q  <= req_addr;
                size_q  <= req_size;
                kind_q  <= dec_burst;
                write_q <= req_write;
                wdata_q <= src_data;
                left_q  <= dec_beats - CW'(1);
                last_q  <= (dec_beats == CW'(1));
            end else begin
                trans_q <= TR_IDLE;
                last_q  <= 1'b0;
            end
        end
    end

    assign htrans  = trans_q;
    assign haddr   = addr_q;
    assign hsize   = size_q;
    assign hburst  = kind_q;
    assign hwrite  = write_q;
    assign a_wdata = wdata_q;
    assign a_last  = last_q;

    // Wait states freeze the address phase.
    assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !hready |=> ($stable(htrans) && $stable(haddr) && $stable(hsize) &&
                     $stable(hburst) && $stable(hwrite)));

    // An accepted incrementing SEQ beat sits one stride above its predecessor.
    assert_incr_stride_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == TR_SEQ && kind_incr(hburst) && $past(hready) &&
         ($past(htrans) == TR_SEQ || $past(htrans) == TR_NSEQ))
        |-> (haddr == $past(haddr) + (AW'(1) << hsize)));

    // A wrapping beat never leaves the aligned wrap block.
    assert_wrap_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == TR_SEQ && kind_wraps(hburst) && $past(hready) &&
         ($past(htrans) == TR_SEQ || $past(htrans) == TR_NSEQ))
        |-> ((haddr & ~((AW'(kind_beats(hburst)) << hsize) - AW'(1))) ==
             ($past(haddr) & ~((AW'(kind_beats(hburst)) << hsize) - AW'(1)))));

    // BUSY is only left towards the next SEQ beat.
    assert_busy_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        htrans == TR_BUSY |=> (htrans == TR_BUSY || htrans == TR_SEQ));

    // No SEQ beat of an incrementing burst starts a boundary block.
    assert_no_block_cross_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == TR_SEQ && kind_incr(hburst)) |-> (haddr[KB_BITS-1:0] != '0));

    // Control stays fixed across the beats of a burst.
    assert_ctrl_const_R10: assert property (@(posedge clk) disable iff (!rst_n)
        htrans == TR_SEQ |-> ($stable(hsize) && $stable(hburst) && $stable(hwrite)));

endmodule

// File: rtl/ahb_burst_seq_data_phase.sv
// Data-phase stage: captures an accepted beat into the data phase, drives
// the write data for it, and reports its completion to the local side.
// Assumes the address stage holds its outputs while hready is low.
module ahb_burst_seq_data_phase #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hready,
    input  logic [1:0]    htrans,
    input  logic          a_write,
    input  logic          a_last,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] hwdata,
    output logic          beat_done,
    output logic          beat_write,
    output logic          beat_last
);

    logic          live_q;
    logic          write_q;
    logic          last_q;
    logic [DW-1:0] wdata_q;

    // Data-phase registers: load the accepted address phase on hready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q  <= 1'b0;
            write_q <= 1'b0;
            last_q  <= 1'b0;
            wdata_q <= '0;
        end else if (hready) begin
            live_q  <= htrans[1];
            write_q <= a_write;
            last_q  <= a_last;
            wdata_q <= a_wdata;
        end
    end

    assign hwdata     = wdata_q;
    assign beat_done  = live_q && hready;
    assign beat_write = write_q;
    assign beat_last  = last_q;

    // Write data is held through wait states.
    assert_wdata_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !hready |=> $stable(hwdata));

    // A completion is reported only when the slave is ready.
    assert_done_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
        beat_done |-> hready);

endmodule

// File: rtl/ahb_burst_seq.sv
// AHB-Lite burst master sequencer top: joins the address-phase controller
// and the data-phase stage and passes the bus read data to the local side.
// Assumes one request at a time and a single-layer bus.
module ahb_burst_seq #(
    parameter int AW      = 32,
    parameter int DW      = 32,
    parameter int LW      = 8,
    parameter int KB_BITS = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic          req_write,
    input  logic [2:0]    req_size,
    input  logic [2:0]    req_burst,
    input  logic [LW-1:0] req_len,
    input  logic          src_valid,
    output logic          src_take,
    input  logic [DW-1:0] src_data,
    output logic          beat_done,
    output logic          beat_write,
    output logic          beat_last,
    output logic [DW-1:0] beat_rdata,
    output logic [1:0]    htrans,
    output logic [AW-1:0] haddr,
    output logic [2:0]    hsize,
    output logic [2:0]    hburst,
    output logic          hwrite,
    output logic [DW-1:0] hwdata,
    input  logic          hready,
    input  logic [DW-1:0] hrdata
);

    localparam int CW = (LW > 5) ? LW : 5;

    logic [DW-1:0] a_wdata;
    logic          a_last;

    ahb_burst_seq_addr_phase #(
        .AW(AW), .DW(DW), .LW(LW), .CW(CW), .KB_BITS(KB_BITS)
    ) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .hready   (hready),
        .req_valid(req_valid),
        .req_addr (req_addr),
        .req_write(req_write),
        .req_size (req_size),
        .req_burst(req_burst),
        .req_len  (req_len),
        .src_valid(src_valid),
        .src_data (src_data),
        .req_ready(req_ready),
        .src_take (src_take),
        .htrans   (htrans),
        .haddr    (haddr),
        .hsize    (hsize),
        .hburst   (hburst),
        .hwrite   (hwrite),
        .a_wdata  (a_wdata),
        .a_last   (a_last)
    );

    ahb_burst_seq_data_phase #(
        .DW(DW)
    ) u_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .hready    (hready),
        .htrans    (htrans),
        .a_write   (hwrite),
        .a_last    (a_last),
        .a_wdata   (a_wdata),
        .hwdata    (hwdata),
        .beat_done (beat_done),
        .beat_write(beat_write),
        .beat_last (beat_last)
    );

    assign beat_rdata = hrdata;

endmodule

// File: tb/tb_ahb_burst_seq.sv
// Bench for the burst sequencer: directed boundary cases followed by
// seeded random requests, source stalls and wait states, checked against
// a request-level model of addresses, transfer types and data order.
module tb_ahb_burst_seq;

    localparam int AW = 32, DW = 32, LW = 8, KB = 10;
    localparam int NREQ = 260, NDIR = 8, LIMIT = 150000;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid, req_ready, req_write;
    logic [AW-1:0] req_addr;
    logic [2:0]    req_size, req_burst;
    logic [LW-1:0] req_len;
    logic          src_valid, src_take;
    logic [DW-1:0] src_data;
    logic          beat_done, beat_write, beat_last;
    logic [DW-1:0] beat_rdata;
    logic [1:0]    htrans;
    logic [AW-1:0] haddr;
    logic [2:0]    hsize, hburst;
    logic          hwrite;
    logic [DW-1:0] hwdata;
    logic          hready;
    logic [DW-1:0] hrdata;

    always #5 clk = ~clk;

    ahb_burst_seq #(.AW(AW), .DW(DW), .LW(LW), .KB_BITS(KB)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_size(req_size), .req_burst(req_burst),
        .req_len(req_len), .src_valid(src_valid), .src_take(src_take),
        .src_data(src_data), .beat_done(beat_done), .beat_write(beat_write),
        .beat_last(beat_last), .beat_rdata(beat_rdata), .htrans(htrans),
        .haddr(haddr), .hsize(hsize), .hburst(hburst), .hwrite(hwrite),
        .hwdata(hwdata), .hready(hready), .hrdata(hrdata)
    );

    int n_checks = 0;
    int n_errors = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Request table.
    logic [AW-1:0] r_addr [NREQ];
    logic          r_write[NREQ];
    logic [2:0]    r_size [NREQ];
    logic [2:0]    r_burst[NREQ];
    logic [LW-1:0] r_len  [NREQ];

    function automatic int beats_of(input logic [2:0] b, input logic [LW-1:0] len);
        case (b)
            3'd0:       return 1;
            3'd1:       return (len == 0) ? 1 : int'(len);
            3'd2, 3'd3: return 4;
            3'd4, 3'd5: return 8;
            default:    return 16;
        endcase
    endfunction

    function automatic logic [AW-1:0] beat_addr(input int k, input int i);
        logic [AW-1:0] st, wb, base;
        st = 32'd1 << r_size[k];
        if (r_burst[k] == 3'd2 || r_burst[k] == 3'd4 || r_burst[k] == 3'd6) begin
            wb   = 32'(beats_of(r_burst[k], r_len[k])) * st;
            base = r_addr[k] & ~(wb - 1);
            return base | ((r_addr[k] + 32'(i) * st) & (wb - 1));
        end
        return r_addr[k] + 32'(i) * st;
    endfunction

    function automatic logic [2:0] exp_burst(input int k);
        logic [AW-1:0] last;
        last = beat_addr(k, beats_of(r_burst[k], r_len[k]) - 1);
        if ((r_burst[k] == 3'd3 || r_burst[k] == 3'd5 || r_burst[k] == 3'd7) &&
            (r_addr[k][AW-1:KB] != last[AW-1:KB]))
            return 3'd1;
        return r_burst[k];
    endfunction

    function automatic bit restart_at(input int k, input int i);
        logic [AW-1:0] a;
        a = beat_addr(k, i);
        return (i == 0) || (r_burst[k][0] && a[KB-1:0] == '0);
    endfunction

    task automatic put_req(input int k, input logic [AW-1:0] a, input logic w,
                           input logic [2:0] s, input logic [2:0] b, input int len);
        r_addr[k] = a; r_write[k] = w; r_size[k] = s; r_burst[k] = b;
        r_len[k] = LW'(len);
    endtask

    // Model state.
    logic [DW-1:0] wq[$];
    bit            act;
    int            cur, ib, tot, nxt, cyc;
    bit            dp_valid, dp_write, dp_last;
    logic [DW-1:0] dp_data;
    bit            taken, src_chg;
    logic          p_hready, p_src_valid;
    logic [1:0]    p_htrans;
    logic [AW-1:0] p_haddr;
    logic [2:0]    p_hsize, p_hburst;
    logic          p_hwrite;
    logic [DW-1:0] p_hwdata;

    initial begin
        void'($urandom(32'd7031));
        // Directed corner cases.
        put_req(0, 32'h0000_0100, 1'b1, 3'd2, 3'd3, 0);   // INCR4 words
        put_req(1, 32'h0000_0038, 1'b0, 3'd2, 3'd2, 0);   // WRAP4 from 0x38
        put_req(2, 32'h0000_0006, 1'b1, 3'd1, 3'd4, 0);   // WRAP8 halfwords
        put_req(3, 32'h0000_03F8, 1'b1, 3'd2, 3'd1, 6);   // INCR over 1KB
        put_req(4, 32'h0000_07F0, 1'b0, 3'd2, 3'd5, 0);   // INCR8 over 1KB
        put_req(5, 32'h0000_0013, 1'b1, 3'd0, 3'd0, 0);   // SINGLE byte
        put_req(6, 32'h0000_000F, 1'b0, 3'd0, 3'd6, 0);   // WRAP16 bytes
        put_req(7, 32'h0000_0C00, 1'b1, 3'd2, 3'd1, 0);   // INCR len 0
        for (int k = NDIR; k < NREQ; k++) begin
            logic [2:0]    s;
            logic [AW-1:0] a;
            s = 3'($urandom % 3);
            a = $urandom & 32'h0003_FFFF;
            if ($urandom % 3 == 0) a = {a[AW-1:KB], 10'h3C0 | 10'($urandom % 64)};
            a = a & ~((32'd1 << s) - 1);
            put_req(k, a, 1'($urandom), s, 3'($urandom % 8), int'($urandom % 21));
        end

        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_write = 1'b0;
        req_size = '0; req_burst = '0; req_len = '0; src_valid = 1'b0;
        src_data = 32'hA5A5_0001; hready = 1'b1; hrdata = '0;
        act = 0; cur = 0; ib = 0; tot = 0; nxt = 0; cyc = 0;
        dp_valid = 0; dp_write = 0; dp_last = 0; dp_data = '0;
        taken = 0; src_chg = 0; p_hready = 1'b1; p_src_valid = 1'b0;

        repeat (3) @(posedge clk);
        #8;
        chk(htrans == 2'b00, "R1", "htrans in reset", 64'(htrans), 0);
        chk(beat_done == 1'b0, "R1", "beat_done in reset", 64'(beat_done), 0);
        @(posedge clk); #2 rst_n = 1'b1;
        @(posedge clk); #8;
        chk(htrans == 2'b00, "R1", "htrans after reset", 64'(htrans), 0);
        chk(beat_done == 1'b0, "R1", "beat_done after reset", 64'(beat_done), 0);
        p_htrans = htrans; p_haddr = haddr; p_hsize = hsize; p_hburst = hburst;
        p_hwrite = hwrite; p_hwdata = hwdata;

        while ((nxt < NREQ || req_valid || (act && ib < tot) || dp_valid) && cyc < LIMIT) begin
            bit calm, active_tr, acc, all_iss, exp_rr, exp_take;
            int issued;
            @(posedge clk); #2;
            cyc++;
            calm = (nxt <= NDIR) && (cyc < 80);
            // Drive inputs.
            if (taken) begin req_valid = 1'b0; taken = 0; end
            if (src_chg) begin src_data = $urandom; src_chg = 0; end
            hready    = calm ? 1'b1 : 1'(($urandom % 4) != 0);
            src_valid = calm ? 1'b1 : 1'(($urandom % 5) != 0);
            hrdata    = $urandom;
            if (!req_valid && nxt < NREQ && (calm || ($urandom % 4) != 0)) begin
                req_valid = 1'b1; req_addr = r_addr[nxt]; req_write = r_write[nxt];
                req_size = r_size[nxt]; req_burst = r_burst[nxt]; req_len = r_len[nxt];
            end
            #6;
            // R2: a wait state froze the previous cycle's outputs.
            if (!p_hready) begin
                chk(htrans == p_htrans && haddr == p_haddr && hsize == p_hsize &&
                    hburst == p_hburst && hwrite == p_hwrite && hwdata == p_hwdata,
                    "R2", "outputs held in wait state", 64'(haddr), 64'(p_haddr));
            end
            // R12 / R11: data-phase completion.
            chk(beat_done == (dp_valid && hready), "R12", "beat_done",
                64'(beat_done), 64'(dp_valid && hready));
            if (dp_valid && hready) begin
                chk(beat_last == dp_last, "R12", "beat_last", 64'(beat_last), 64'(dp_last));
                chk(beat_write == dp_write, "R12", "beat_write", 64'(beat_write), 64'(dp_write));
                if (dp_write) chk(hwdata == dp_data, "R11", "hwdata", 64'(hwdata), 64'(dp_data));
                else chk(beat_rdata == hrdata, "R12", "beat_rdata", 64'(beat_rdata), 64'(hrdata));
            end
            // Bus address phase against the model.
            active_tr = htrans[1];
            acc = 0;
            if (active_tr) begin
                if (!act || ib >= tot) begin
                    chk(0, "R6", "transfer beyond beat count", 64'(haddr), 0);
                end else begin
                    logic [AW-1:0] ea;
                    bit rs;
                    ea = beat_addr(cur, ib);
                    rs = restart_at(cur, ib);
                    chk(haddr == ea, r_burst[cur][0] || r_burst[cur] == 0 ? "R4" : "R5",
                        "haddr", 64'(haddr), 64'(ea));
                    chk(htrans == (rs ? 2'b10 : 2'b11), (rs && ib > 0) ? "R8" : "R3",
                        "htrans", 64'(htrans), rs ? 64'h2 : 64'h3);
                    chk(hburst == exp_burst(cur), exp_burst(cur) != r_burst[cur] ? "R9" : "R10",
                        "hburst", 64'(hburst), 64'(exp_burst(cur)));
                    chk(hsize == r_size[cur] && hwrite == r_write[cur], "R10", "hsize/hwrite",
                        64'({hsize, hwrite}), 64'({r_size[cur], r_write[cur]}));
                    if (hready) begin
                        acc = 1;
                        dp_write = r_write[cur];
                        dp_last  = (ib == tot - 1);
                        if (wq.size() == 0) chk(0, "R11", "no captured data", 0, 1);
                        else dp_data = wq.pop_front();
                        ib++;
                    end
                end
            end else if (htrans == 2'b01) begin
                chk(act && ib > 0 && ib < tot && !restart_at(cur, ib), "R7",
                    "BUSY outside a burst", 64'(ib), 64'(tot));
                if (act && ib < tot)
                    chk(haddr == beat_addr(cur, ib), "R7", "BUSY address",
                        64'(haddr), 64'(beat_addr(cur, ib)));
                if (p_hready) chk(!p_src_valid, "R7", "BUSY without stall", 64'(p_src_valid), 0);
            end else if (act && ib < tot) begin
                chk(ib > 0 && restart_at(cur, ib), "R8", "IDLE inside a burst", 64'(ib), 64'(tot));
                if (p_hready) chk(!p_src_valid, "R8", "IDLE without stall", 64'(p_src_valid), 0);
            end
            // R13 / R11: handshakes.
            issued   = (act ? ib : 0) + ((active_tr && !acc) ? 1 : 0);
            all_iss  = !act || (issued >= tot);
            exp_rr   = hready && src_valid && all_iss;
            exp_take = hready && src_valid && ((act && issued < tot) || (all_iss && req_valid));
            chk(req_ready == exp_rr, "R13", "req_ready", 64'(req_ready), 64'(exp_rr));
            chk(src_take == exp_take, "R11", "src_take", 64'(src_take), 64'(exp_take));
            if (hready) dp_valid = acc;
            if (src_take) begin wq.push_back(src_data); src_chg = 1; end
            if (req_valid && req_ready) begin
                if (act && ib < tot) chk(0, "R6", "request ended early", 64'(ib), 64'(tot));
                act = 1; cur = nxt; ib = 0; tot = beats_of(r_burst[nxt], r_len[nxt]);
                nxt++; taken = 1;
            end
            p_hready = hready; p_src_valid = src_valid; p_htrans = htrans;
            p_haddr = haddr; p_hsize = hsize; p_hburst = hburst;
            p_hwrite = hwrite; p_hwdata = hwdata;
        end
        if (cyc >= LIMIT) chk(0, "R6", "watchdog expired", 64'(cyc), LIMIT);
        chk(nxt == NREQ && !(act && ib < tot), "R6", "all requests completed", 64'(nxt), NREQ);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule